// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block keeps the request, in-service and previous-level state for eight interrupt lines. It also holds a rotatable priority base. Each input is sampled on the clock. A per-line trigger select decides whether the line is level-sensitive or rising-edge-sensitive. Masked lines are removed from the pending set. The remaining requests are ranked from the current base. The winner is presented only if it outranks every line already in service.

A host drives an acknowledge strobe when it takes the presented line. The acknowledge marks that line in service and consumes an edge request. With automatic end-of-interrupt enabled, the acknowledge leaves nothing in service, and it can optionally rotate the base so that the serviced line drops to lowest priority. An optional nesting control hides the cascade line (line 2) from the in-service ranking, so that further requests on a cascaded controller can still get through.

Top module: `prio_resolver`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the request, in-service and previous-level registers and the priority base to zero, so win_valid is 0 afterwards.
- R2: A line whose level_sel bit is 1 is level-sensitive: after each rising edge its req_q bit equals the req_in value sampled at that edge.
- R3: A line whose level_sel bit is 0 sets its req_q bit only when req_in is 1 at an edge and was 0 at the previous edge. A held-high or low input leaves a pending bit unchanged.
- R4: Line l has priority position (l - base_q) mod 8, and position 0 is highest. The winning line, which is the pending unmasked line at the lowest position, appears on win_line.
- R5: A line with its mask_in bit set to 1 is never the winner.
- R6: win_valid is 1 only when the winner's position is strictly lower than the position of the highest-ranked in-service line. An empty in-service set counts as position 8.
- R7: With nest_en set to 1, in-service bit 2 is ignored in the ranking of R6.
- R8: ack while win_valid is 1 with aeoi_en at 0 sets isr_q[win_line]. It clears req_q[win_line] only for an edge-sensitive line. A level-sensitive line keeps its request.
- R9: ack while win_valid is 1 with aeoi_en at 1 leaves isr_q unchanged. It still clears the request of an edge-sensitive line.
- R10: If aeoi_rot_en is also 1 in the case of R9, base_q becomes (win_line + 1) mod 8.
- R11: base_wr loads base_val into base_q and takes precedence over R10. ack while win_valid is 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Raw interrupt inputs |
| mask_in | input | 8 | 1 removes a line from the candidate set |
| level_sel | input | 8 | 1 selects level-sensitive, 0 selects edge-sensitive |
| base_wr | input | 1 | Load strobe for the priority base |
| base_val | input | 3 | Value loaded into the priority base |
| nest_en | input | 1 | Ignore in-service line 2 in the ranking |
| aeoi_en | input | 1 | Automatic end-of-interrupt on acknowledge |
| aeoi_rot_en | input | 1 | Rotate the base on automatic end-of-interrupt |
| ack | input | 1 | Acknowledge of the presented line |
| win_line | output | 3 | Winning line number |
| win_valid | output | 1 | Winning line outranks all in-service lines |
| base_q | output | 3 | Current priority base |
| req_q | output | 8 | Request register |
| isr_q | output | 8 | In-service register |

## Verification
Register results are due one rising edge after the stimulus. This covers req_q, isr_q and base_q following a sampled input, an acknowledge or a base load. The bench drives inputs on the falling edge and reads these registers at the next falling edge. win_line and win_valid are combinational from the registers and from mask_in and nest_en. A change to those inputs is checked in the same half-cycle, without waiting for a clock edge. A change in register state is checked at the falling edge after the update.

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int N    = 8,
  parameter int CASC = 2,
  localparam int W   = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] mask_in,
  input  logic [N-1:0] level_sel,
  input  logic         base_wr,
  input  logic [W-1:0] base_val,
  input  logic         nest_en,
  input  logic         aeoi_en,
  input  logic         aeoi_rot_en,
  input  logic         ack,
  output logic [W-1:0] win_line,
  output logic         win_valid,
  output logic [W-1:0] base_q,
  output logic [N-1:0] req_q,
  output logic [N-1:0] isr_q
);

  logic [N-1:0] prev_q;
  logic [N-1:0] cand, isr_rank, win_hot, take;
  logic [W:0]   cand_pos, isr_pos;

  function automatic logic [W:0] first_pos(input logic [N-1:0] v, input logic [W-1:0] b);
    logic [W:0] r;
    r = (W+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      logic [W-1:0] idx;
      idx = W'(p) + b;
      if (v[idx]) r = (W+1)'(p);
    end
    return r;
  endfunction

  assign cand     = req_q & ~mask_in;
  assign isr_rank = nest_en ? (isr_q & ~(N'(1) << CASC)) : isr_q;
  assign cand_pos = first_pos(cand, base_q);
  assign isr_pos  = first_pos(isr_rank, base_q);
  assign win_line = cand_pos[W-1:0] + base_q;
  assign win_valid = (cand_pos < isr_pos);

  assign win_hot = N'(1) << win_line;
  assign take    = (ack && win_valid) ? win_hot : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      req_q  <= '0;
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      prev_q <= req_in;
      for (int i = 0; i < N; i++) begin
        if (level_sel[i])
          req_q[i] <= req_in[i];
        else if (req_in[i] && !prev_q[i])
          req_q[i] <= 1'b1;
        else if (take[i])
          req_q[i] <= 1'b0;
      end
      if (!aeoi_en)
        isr_q <= isr_q | take;
      if (base_wr)
        base_q <= base_val;
      else if (ack && win_valid && aeoi_en && aeoi_rot_en)
        base_q <= win_line + W'(1);
    end
  end

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int N    = 8,
  parameter int CASC = 2,
  localparam int W   = $clog2(N)
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req_in,
  input logic [N-1:0] mask_in,
  input logic [N-1:0] level_sel,
  input logic         base_wr,
  input logic [W-1:0] base_val,
  input logic         nest_en,
  input logic         aeoi_en,
  input logic         aeoi_rot_en,
  input logic         ack,
  input logic [W-1:0] win_line,
  input logic         win_valid,
  input logic [W-1:0] base_q,
  input logic [N-1:0] req_q,
  input logic [N-1:0] isr_q
);

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (req_q == '0 && isr_q == '0 && base_q == '0));

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((req_q & $past(level_sel)) == ($past(req_in) & $past(level_sel))));

  assert_winner_legal_R5: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (req_q[win_line] && !mask_in[win_line]));

  assert_ack_sets_isr_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && win_valid && !aeoi_en) |=> isr_q[$past(win_line)]);

  assert_aeoi_isr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (aeoi_en || !ack) |=> $stable(isr_q));

  assert_aeoi_rotate_R10: assert property (@(posedge clk) disable iff (rst)
    (ack && win_valid && aeoi_en && aeoi_rot_en && !base_wr) |=> (base_q == $past(win_line) + W'(1)));

  assert_base_load_R11: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> (base_q == $past(base_val)));

endmodule

bind prio_resolver prio_resolver_chk #(.N(N), .CASC(CASC)) u_chk (.*);

// File: tb/prio_resolver_bench.sv
`timescale 1ns/1ps
module prio_resolver_bench;
  logic       clk = 0;
  logic       rst;
  logic [7:0] req_in, mask_in, level_sel;
  logic       base_wr, nest_en, aeoi_en, aeoi_rot_en, ack;
  logic [2:0] base_val;
  logic [2:0] win_line, base_q;
  logic       win_valid;
  logic [7:0] req_q, isr_q;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  prio_resolver u_prio_resolver (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_in = 0; mask_in = 0; level_sel = 0; base_wr = 0; base_val = 0;
    nest_en = 0; aeoi_en = 0; aeoi_rot_en = 0; ack = 0;
    step();
    rst = 0;
  endtask

  task automatic pulse(input logic [7:0] v);
    req_in = v; step(); req_in = 0; step();
  endtask

  task automatic do_ack();
    ack = 1; step(); ack = 0;
  endtask

  task automatic set_base(input logic [2:0] b);
    base_wr = 1; base_val = b; step(); base_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req", req_q, 0); chk("R1 isr", isr_q, 0);
    chk("R1 base", base_q, 0); chk("R1 valid", win_valid, 0);
  endtask

  task automatic t_level();
    do_reset();
    level_sel = 8'h10; req_in = 8'h10; step();
    chk("R2 high", req_q, 8'h10); chk("R2 line", win_line, 4); chk("R2 valid", win_valid, 1);
    req_in = 0; step();
    chk("R2 low", req_q, 0); chk("R2 novalid", win_valid, 0);
  endtask

  task automatic t_edge();
    do_reset();
    req_in = 8'h08; step(); chk("R3 rise", req_q, 8'h08);
    step(); chk("R3 held", req_q, 8'h08);
    req_in = 0; step(); chk("R3 low keeps", req_q, 8'h08);
  endtask

  task automatic t_prio();
    do_reset();
    pulse(8'h82);
    chk("R4 base0", win_line, 1);
    set_base(2); chk("R4 base2 reg", base_q, 2); chk("R4 base2", win_line, 7);
    set_base(7); chk("R4 base7", win_line, 7);
    set_base(1); chk("R4 base1", win_line, 1);
    mask_in = 8'h02; #1 chk("R5 mask1", win_line, 7); chk("R5 mask1 v", win_valid, 1);
    mask_in = 8'h82; #1 chk("R5 mask all", win_valid, 0);
    mask_in = 0;
  endtask

  task automatic t_isr();
    do_reset();
    pulse(8'h08); do_ack();
    chk("R8 isr", isr_q, 8'h08); chk("R8 req clr", req_q, 0); chk("R6 empty", win_valid, 0);
    pulse(8'h20); chk("R6 lower", win_valid, 0);
    pulse(8'h08); mask_in = 8'h20; #1 chk("R6 equal", win_valid, 0);
    mask_in = 0; pulse(8'h02);
    chk("R6 higher", win_valid, 1); chk("R6 line", win_line, 1);
  endtask

  task automatic t_nest();
    do_reset();
    pulse(8'h04); do_ack(); chk("R7 isr2", isr_q, 8'h04);
    pulse(8'h20); chk("R7 off", win_valid, 0);
    nest_en = 1; #1 chk("R7 on", win_valid, 1); chk("R7 line", win_line, 5);
    nest_en = 0;
  endtask

  task automatic t_ack_level();
    do_reset();
    level_sel = 8'h01; req_in = 8'h01; step();
    do_ack();
    chk("R8 lvl isr", isr_q, 8'h01); chk("R8 lvl req", req_q, 8'h01); chk("R8 lvl valid", win_valid, 0);
    req_in = 0;
  endtask

  task automatic t_aeoi();
    do_reset();
    aeoi_en = 1;
    pulse(8'h40); do_ack();
    chk("R9 isr", isr_q, 0); chk("R9 req", req_q, 0); chk("R9 base", base_q, 0);
    aeoi_rot_en = 1;
    pulse(8'h40); do_ack(); chk("R10 base", base_q, 7);
    pulse(8'h50); chk("R10 win", win_line, 4);
    do_ack(); chk("R10 base2", base_q, 5); chk("R10 req", req_q, 8'h40);
    ack = 1; base_wr = 1; base_val = 3; step(); ack = 0; base_wr = 0;
    chk("R11 wr wins", base_q, 3);
  endtask

  task automatic t_idle_ack();
    do_reset();
    do_ack();
    chk("R11 idle isr", isr_q, 0); chk("R11 idle req", req_q, 0); chk("R11 idle base", base_q, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_level(); t_edge(); t_prio(); t_isr();
        t_nest(); t_ack_level(); t_aeoi(); t_idle_ack();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule